// File: doc/BRIEF.md
# Addressed Serial Front End for a Quad 12-bit Converter

This block is the digital side of a four-channel 12-bit converter. A host sends 16-bit words over three wires: an active-low frame enable, a serial clock and a data line. Each word carries a 12-bit code, a 2-bit device address and a 2-bit channel number. When a full word has arrived and its address matches the two strap inputs, the code goes into the staging register of the chosen channel. Words for other addresses are dropped here, but they still leave through the chain output. That output is the last stage of the shift register, so several devices can be wired in series.

Each channel has two registers. The host fills the staging registers one at a time. A low level on the load input then copies all four staging registers into the output registers in the same cycle, so all four channels change together. A low level on the clear input zeroes the output registers but leaves the staging registers alone, so a later load brings back the earlier codes. Every pin is sampled by a faster system clock through synchronizers, and serial clock falling edges are found in that domain.

Top module: `qdac_serial_front`

## Requirements
- R1: After system reset, all four output codes read zero and the chain output is 0.
- R2: A word is sent most significant bit first. Bits 15..4 hold the code, bits 3..2 hold the address (bit 3 is compared with strap[1], bit 2 with strap[0]), and bits 1..0 select the channel. The code is written on the sixteenth serial clock falling edge while frame_n is low.
- R3: Channel select value k (00, 01, 10, 11) addresses channel k, which appears on dac_code[k*12 +: 12].
- R4: A word whose address bits differ from the straps writes no staging register.
- R5: chain_out is the most significant shift-register bit. The bits of a word, including a word for another address, come out of chain_out in order while the next 16 bits are shifted in.
- R6: Output codes change only while load_n is low. Load copies all four staging registers together.
- R7: A low clear_n forces every output code to zero and leaves the staging registers unchanged, so a later load restores the earlier codes.
- R8: A frame that ends before sixteen falling edges writes nothing. Falling edges after the sixteenth in the same frame cause no second write.
- R9: When clear_n and load_n are both low, the outputs stay at zero.
- R10: Serial clock edges while frame_n is high do not shift and do not advance the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low synchronous system reset |
| frame_n | input | 1 | Active-low frame enable |
| sclk | input | 1 | Serial clock; data is taken on its falling edges |
| sdata | input | 1 | Serial data in |
| strap | input | 2 | Device address straps |
| load_n | input | 1 | Active-low load of all output registers |
| clear_n | input | 1 | Active-low clear of all output registers |
| dac_code | output | 48 | Four output codes; channel k at bits k*12+11..k*12 |
| chain_out | output | 1 | Shift-register tail for daisy chaining |

## Verification
Two pairs of functions can land in the same cycle. The first pair is clear and load. The bench holds both strobes low together and expects zero outputs, then expects the outputs to stay at zero after both are released. The second pair is the chain output and the address filter. While a matching word is being shifted in, the bench reads chain_out bit by bit and expects the earlier non-matching word in order. After the next load it expects the targeted channel to keep its old code.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   // Number of flops used to bring each pin into the system clock domain.
   localparam int QD_SYNC_DEPTH = 2;

   // Idle levels of the synchronised control bundle {frame_n, sclk, sdata, load_n, clear_n}.
   localparam logic [4:0] QD_PIN_IDLE = 5'b10011;

   // Compares the address field of a word with the strap inputs.
   function automatic logic qd_addr_hit(input logic [1:0] field, input logic [1:0] straps);
      return field == straps;
   endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("qdac_sync: W must be at least 1");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx #(
   parameter int FRAME_W = 16,
   localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_n,
   input  logic               sclk,
   input  logic               sdata,
   output logic [FRAME_W-1:0] frame_q,
   output logic               word_done,
   output logic [CNT_W-1:0]   bit_cnt,
   output logic               tail
);
   logic sclk_d;
   logic fall;

   assign fall = sclk_d & ~sclk;
   assign tail = frame_q[FRAME_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_d    <= 1'b0;
         frame_q   <= '0;
         bit_cnt   <= '0;
         word_done <= 1'b0;
      end else begin
         sclk_d    <= sclk;
         word_done <= 1'b0;
         if (frame_n) begin
            bit_cnt <= '0;
         end else if (fall) begin
            frame_q <= {frame_q[FRAME_W-2:0], sdata};
            if (bit_cnt != CNT_W'(FRAME_W)) bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(FRAME_W - 1)) word_done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/qdac_latch_bank.sv
module qdac_latch_bank #(
   parameter int CODE_W = 12,
   parameter int SEL_W  = 2,
   localparam int CHANS = 1 << SEL_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [SEL_W-1:0]          wr_sel,
   input  logic [CODE_W-1:0]         wr_code,
   input  logic                      load_n,
   input  logic                      clear_n,
   output logic [CHANS*CODE_W-1:0]   in_flat,
   output logic [CHANS*CODE_W-1:0]   out_flat
);
   generate
      for (genvar k = 0; k < CHANS; k++) begin : g_chan
         logic [CODE_W-1:0] stage_r;
         logic [CODE_W-1:0] hold_r;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_r <= '0;
            end else if (wr_en && wr_sel == SEL_W'(k)) begin
               stage_r <= wr_code;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n || !clear_n) begin
               hold_r <= '0;
            end else if (!load_n) begin
               hold_r <= stage_r;
            end
         end

         assign in_flat[k*CODE_W +: CODE_W]  = stage_r;
         assign out_flat[k*CODE_W +: CODE_W] = hold_r;
      end
   endgenerate
endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front #(
   parameter int CODE_W = 12,
   parameter int ADDR_W = 2,
   parameter int SEL_W  = 2,
   parameter int SYNC_STAGES = qdac_pkg::QD_SYNC_DEPTH,
   localparam int CHANS   = 1 << SEL_W,
   localparam int FRAME_W = CODE_W + ADDR_W + SEL_W,
   localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_n,
   input  logic                    sclk,
   input  logic                    sdata,
   input  logic [ADDR_W-1:0]       strap,
   input  logic                    load_n,
   input  logic                    clear_n,
   output logic [CHANS*CODE_W-1:0] dac_code,
   output logic                    chain_out
);
   generate
      if (CODE_W < 1 || SEL_W < 1) begin : g_bad_geom
         $error("qdac_serial_front: CODE_W and SEL_W must be positive");
      end
      if (ADDR_W != 2) begin : g_bad_addr
         $error("qdac_serial_front: address field must be 2 bits");
      end
   endgenerate

   logic frame_s, sclk_s, sdata_s, load_s, clear_s;
   logic [FRAME_W-1:0]      frame_q;
   logic                    word_done;
   logic [CNT_W-1:0]        bit_cnt;
   logic                    wr_en;
   logic [CHANS*CODE_W-1:0] in_flat;

   qdac_sync #(
      .W(5), .STAGES(SYNC_STAGES), .RST_VAL(qdac_pkg::QD_PIN_IDLE)
   ) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({frame_n, sclk, sdata, load_n, clear_n}),
      .q({frame_s, sclk_s, sdata_s, load_s, clear_s})
   );

   qdac_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .frame_n(frame_s), .sclk(sclk_s), .sdata(sdata_s),
      .frame_q(frame_q), .word_done(word_done),
      .bit_cnt(bit_cnt), .tail(chain_out)
   );

   assign wr_en = word_done &&
                  qdac_pkg::qd_addr_hit(frame_q[SEL_W +: ADDR_W], strap);

   qdac_latch_bank #(.CODE_W(CODE_W), .SEL_W(SEL_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en),
      .wr_sel(frame_q[SEL_W-1:0]),
      .wr_code(frame_q[FRAME_W-1 -: CODE_W]),
      .load_n(load_s), .clear_n(clear_s),
      .in_flat(in_flat), .out_flat(dac_code)
   );
endmodule

// File: rtl/qdac_front_chk.sv
module qdac_front_chk #(
   parameter int WIDTH = 48,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_s,
   input logic             load_s,
   input logic             clear_s,
   input logic             wr_en,
   input logic [CNT_W-1:0] bit_cnt,
   input logic [WIDTH-1:0] in_flat,
   input logic [WIDTH-1:0] out_flat
);
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_s && load_s) |=> $stable(out_flat)); // R6
   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_s && !load_s) |=> out_flat == $past(in_flat)); // R6
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_s |=> out_flat == '0); // R7
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_s && !load_s) |=> out_flat == '0); // R9
   AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(in_flat)); // R7
   AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R8
   AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_s |=> bit_cnt == '0); // R10
endmodule

bind qdac_serial_front qdac_front_chk #(
   .WIDTH(CHANS*CODE_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_s(frame_s), .load_s(load_s),
   .clear_s(clear_s), .wr_en(wr_en), .bit_cnt(bit_cnt),
   .in_flat(in_flat), .out_flat(dac_code)
);

// File: tb/sim_qdac_serial_front.sv
module sim_qdac_serial_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
   logic        load_n = 1'b1, clear_n = 1'b1;
   logic [1:0]  strap = 2'b10;
   logic [47:0] dac_code;
   logic        chain_out;

   int nchk = 0, nerr = 0;
   logic [11:0] in_m [4];
   logic [11:0] out_m [4];
   logic [31:0] cap;
   logic [47:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   qdac_serial_front u0 (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdata(sdata),
      .strap(strap), .load_n(load_n), .clear_n(clear_n),
      .dac_code(dac_code), .chain_out(chain_out)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] frm(input logic [11:0] c, input logic [1:0] a,
                                       input logic [1:0] s);
      return {c, a, s};
   endfunction

   function automatic logic [47:0] pack_out();
      logic [47:0] r;
      for (int i = 0; i < 4; i++) r[i*12 +: 12] = out_m[i];
      return r;
   endfunction

   // Driver side of the scoreboard: push the expected output bus, wait for the monitor.
   task automatic expect_out(input string tag);
      exp_q.push_back(pack_out());
      tag_q.push_back(tag);
      wait (exp_q.size() == 0);
      tick(1);
   endtask

   // Monitor: compares the output bus against each queued expectation.
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            logic [47:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, dac_code, e);
         end
      end
   end

   // Sends n bits of w, MSB first, capturing chain_out before each falling edge.
   task automatic send(input logic [31:0] w, input int n);
      frame_n = 1'b0;
      tick(4);
      for (int i = n - 1; i >= 0; i--) begin
         sdata = w[i];
         sclk  = 1'b1;
         tick(4);
         cap  = {cap[30:0], chain_out};
         sclk = 1'b0;
         tick(4);
      end
      frame_n = 1'b1;
      tick(6);
   endtask

   task automatic do_load();
      load_n = 1'b0;
      tick(6);
      load_n = 1'b1;
      tick(6);
      for (int i = 0; i < 4; i++) out_m[i] = in_m[i];
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin
         in_m[i] = '0;
         out_m[i] = '0;
      end
      cap = '0;
      tick(5);
      rst_n = 1'b1;
      tick(4);
      // R1 reset state
      check("R1 reset codes", dac_code, 48'h0);
      check("R1 reset chain_out", {47'h0, chain_out}, 48'h0);

      // R2 R3: one write per channel; R6: no change before load
      send({16'h0, frm(12'h123, 2'b10, 2'b00)}, 16); in_m[0] = 12'h123;
      send({16'h0, frm(12'hABC, 2'b10, 2'b01)}, 16); in_m[1] = 12'hABC;
      send({16'h0, frm(12'hFFF, 2'b10, 2'b10)}, 16); in_m[2] = 12'hFFF;
      send({16'h0, frm(12'h001, 2'b10, 2'b11)}, 16); in_m[3] = 12'h001;
      expect_out("R6 outputs hold before load");
      do_load();
      expect_out("R2 R3 load of four channels");

      // R4 R5: non-matching word, then read it out of the chain
      send({16'h0, frm(12'h555, 2'b01, 2'b00)}, 16);
      check("R5 chain_out after word", {47'h0, chain_out}, 48'h0);
      send({16'h0, frm(12'h777, 2'b10, 2'b01)}, 16); in_m[1] = 12'h777;
      check("R5 pass-through of other-address word", {32'h0, cap[15:0]},
            {32'h0, frm(12'h555, 2'b01, 2'b00)});
      do_load();
      expect_out("R4 mismatch keeps channel 0");

      // R8: short frame writes nothing
      send({22'h0, 10'h3FF}, 10);
      do_load();
      expect_out("R8 short frame ignored");

      // R8: long frame writes only the first 16 bits
      send({12'h0, frm(12'h4A5, 2'b10, 2'b11), 4'hF}, 20); in_m[3] = 12'h4A5;
      do_load();
      expect_out("R8 extra edges no rewrite");

      // R7: clear spares staging registers
      clear_n = 1'b0;
      tick(6);
      for (int i = 0; i < 4; i++) out_m[i] = '0;
      expect_out("R7 clear zeroes outputs");
      clear_n = 1'b1;
      tick(6);
      expect_out("R7 stays zero after clear release");
      do_load();
      expect_out("R7 load restores codes");

      // R9: clear and load together
      clear_n = 1'b0;
      load_n  = 1'b0;
      tick(6);
      for (int i = 0; i < 4; i++) out_m[i] = '0;
      expect_out("R9 clear beats load");
      clear_n = 1'b1;
      load_n  = 1'b1;
      tick(6);
      expect_out("R9 zero after release");

      // R10: clock edges with frame high do nothing
      send({16'h0, frm(12'h9C3, 2'b10, 2'b10)}, 16); in_m[2] = 12'h9C3;
      for (int i = 0; i < 16; i++) begin
         sdata = ~chain_out;
         sclk = 1'b1; tick(4);
         sclk = 1'b0; tick(4);
      end
      check("R10 chain_out unchanged", {47'h0, chain_out}, {47'h0, 1'b1});
      send({16'h0, frm(12'h000, 2'b11, 2'b00)}, 16);
      check("R10 register kept across idle edges", {32'h0, cap[15:0]},
            {32'h0, frm(12'h9C3, 2'b10, 2'b10)});
      do_load();
      expect_out("R10 final outputs");

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule